// File: doc/BRIEF.md
# Cyclic Prefix Inserter

This block sits in a single-carrier transmit chain and turns a stream of complex samples, grouped in blocks of `N`, into a stream of blocks of `N+P` samples. Each outgoing block opens with a guard section of `P` samples. This guard section is a copy of the last `P` samples of the same input block. The whole input block follows it, in order. The upstream source never sees back-pressure, so the block has no ready signal.

The incoming samples are written into a simple dual-port RAM of depth `N`, at write addresses that wrap modulo `N`. The read side does not wait for the whole block to land. The write of the sample with index `N-P` arms the reader. On the next cycle the reader fetches the location that has just been written. For the following `P` cycles, writing and reading of the buffer run side by side. After the tail has arrived, only reads continue: the read address wraps to zero and steps through the full block. The RAM has one cycle of read latency, and the output valid and start-of-block flags are delayed by the same amount.

Top module: `cyclic_prefix_inserter`

## Requirements
- R1: While reset is asserted and after it is released with no input, `outValid` and `outSob` are 0.
- R2: Each output block consists of exactly `N+P` samples, presented on consecutive cycles with `outValid` high.
- R3: Output positions 0 to `P-1` of a block carry input samples `N-P` to `N-1` of that block, in that order. Both the real and the imaginary parts are copied unchanged.
- R4: Output positions `P` to `N+P-1` of a block carry input samples 0 to `N-1` of that block, in that order.
- R5: `outSob` is 1 on the first output sample of each block (the first prefix sample) and 0 on every other output cycle.
- R6: When input sample `N-P` of a block is accepted in cycle c, the first prefix sample of that block appears on the outputs in cycle c+2.
- R7: Input cycles with `inValid` low are ignored whatever `inRe`/`inIm` hold. Such idle cycles may occur anywhere before sample `N-P` of a block, and they do not alter the output.
- R8: The reader may start a new block on the same cycle that the previous block ends. The next block's samples overwrite buffer locations only after those locations have been read, so consecutive blocks come out correct and without a gap.
- R9: Input contract: the last `P` samples of a block arrive on consecutive cycles, and at least `P` idle cycles separate the last sample of one block from the first sample of the next. Sample indices count from reset modulo `N`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inRe | input | DATA_W | Input sample, real part |
| inIm | input | DATA_W | Input sample, imaginary part |
| outValid | output | 1 | Output sample valid |
| outSob | output | 1 | First sample of an output block |
| outRe | output | DATA_W | Output sample, real part |
| outIm | output | DATA_W | Output sample, imaginary part |

## Verification
The first prefix sample of a block is due two cycles after the cycle that presents input sample `N-P`. Each later output sample is due exactly one cycle after the one before it. With the minimum idle gap, the next block's first sample is due in the cycle right after the previous block's last sample. The bench drives inputs on the falling edge and records every valid output on the falling edge, together with a cycle stamp. It computes each block's expected start cycle at the moment it drives sample `N-P`, and compares the recorded stamps against that value plus the sample position.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  // strobes from the sequencer to the buffer datapath
  typedef struct packed {
    logic wrEn;     // store the incoming sample this cycle
    logic rdEn;     // fetch one sample from the buffer this cycle
    logic rdFirst;  // the fetch is the first prefix sample of a block
  } cpiStrobes_t;

endpackage

// File: rtl/cpi_ram.sv
module cpi_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // read-before-write on a shared address: the old word is returned
  always_ff @(posedge clk) begin
    if (rdEn) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/cpi_ctrl.sv
module cpi_ctrl
  import cpi_pkg::*;
#(
  parameter int N = 32,
  parameter int P = 8,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(N + P + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output cpiStrobes_t   strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  logic [AW-1:0] wrCnt;
  logic [CW-1:0] rdCnt;
  logic          rdActive;
  logic          tailHit;
  logic          lastRead;

  assign tailHit  = inValid && (wrCnt == AW'(N - P));
  assign lastRead = rdActive && (rdCnt == CW'(N + P - 1));

  // write pointer, one step per accepted sample, wraps modulo N
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= '0;
    end else if (inValid) begin
      wrCnt <= (wrCnt == AW'(N - 1)) ? '0 : wrCnt + 1'b1;
    end
  end

  // reader: armed by the write of sample N-P, runs N+P cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdCnt    <= '0;
      rdAddr   <= '0;
    end else if (tailHit) begin
      rdActive <= 1'b1;
      rdCnt    <= '0;
      rdAddr   <= AW'(N - P);
    end else if (rdActive) begin
      rdActive <= !lastRead;
      rdCnt    <= rdCnt + 1'b1;
      rdAddr   <= (rdAddr == AW'(N - 1)) ? '0 : rdAddr + 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn    = inValid;
    strobes.rdEn    = rdActive;
    strobes.rdFirst = rdActive && (rdCnt == '0);
  end

  assign wrAddr = wrCnt;

  // R9
  tail_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdActive && (rdCnt < CW'(P - 1))) |-> inValid);

  // R9
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    tailHit |-> (!rdActive || lastRead));

  // R3
  prefix_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdFirst |-> (rdAddr == AW'(N - P)));

  // R4
  body_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdActive && (rdCnt == CW'(P))) |-> (rdAddr == '0));

endmodule

// File: rtl/cpi_datapath.sv
module cpi_datapath
  import cpi_pkg::*;
#(
  parameter int N = 32,
  parameter int P = 8,
  parameter int DATA_W = 12,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(N + P + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cpiStrobes_t       strobes,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] inRe,
  input  logic [DATA_W-1:0] inIm,
  output logic              outValid,
  output logic              outSob,
  output logic [DATA_W-1:0] outRe,
  output logic [DATA_W-1:0] outIm
);

  logic [2*DATA_W-1:0] ramQ;
  logic [CW-1:0]       lenCnt;

  cpi_ram #(.DEPTH(N), .WIDTH(2 * DATA_W)) u_ram (
    .clk   (clk),
    .wrEn  (strobes.wrEn),
    .wrAddr(wrAddr),
    .wrData({inRe, inIm}),
    .rdEn  (strobes.rdEn),
    .rdAddr(rdAddr),
    .rdData(ramQ)
  );

  // flags follow the one-cycle read latency of the buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSob   <= 1'b0;
    end else begin
      outValid <= strobes.rdEn;
      outSob   <= strobes.rdFirst;
    end
  end

  assign outRe = ramQ[2*DATA_W-1:DATA_W];
  assign outIm = ramQ[DATA_W-1:0];

  // run-length counter used only by the checks below
  always_ff @(posedge clk) begin
    if (!rstN)         lenCnt <= '0;
    else if (outSob)   lenCnt <= CW'(1);
    else if (outValid) lenCnt <= lenCnt + 1'b1;
  end

  // R5
  sob_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSob |-> outValid);

  // R5
  run_opens_sob_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outSob);

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (lenCnt == CW'(N + P)));

  // R8
  chain_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSob && $past(outValid)) |-> (lenCnt == CW'(N + P)));

endmodule

// File: rtl/cyclic_prefix_inserter.sv
module cyclic_prefix_inserter
  import cpi_pkg::*;
#(
  parameter int N = 32,
  parameter int P = 8,
  parameter int DATA_W = 12,
  localparam int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inRe,
  input  logic [DATA_W-1:0] inIm,
  output logic              outValid,
  output logic              outSob,
  output logic [DATA_W-1:0] outRe,
  output logic [DATA_W-1:0] outIm
);

  cpiStrobes_t   strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  cpi_ctrl #(.N(N), .P(P)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr)
  );

  cpi_datapath #(.N(N), .P(P), .DATA_W(DATA_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .inRe    (inRe),
    .inIm    (inIm),
    .outValid(outValid),
    .outSob  (outSob),
    .outRe   (outRe),
    .outIm   (outIm)
  );

endmodule

// File: tb/cyclic_prefix_inserter_bench.sv
module cyclic_prefix_inserter_bench;

  localparam int N = 16;
  localparam int P = 4;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [W-1:0] inRe, inIm;
  logic         outValid, outSob;
  logic [W-1:0] outRe, outIm;

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;

  logic [W-1:0] capRe[$], capIm[$], expRe[$], expIm[$];
  bit           capSob[$], expSob[$];
  int           capCyc[$], expStart[$];

  always #10 clk = ~clk;

  cyclic_prefix_inserter #(.N(N), .P(P), .DATA_W(W)) u_cyclic_prefix_inserter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outSob(outSob), .outRe(outRe), .outIm(outIm)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN && outValid) begin
      capRe.push_back(outRe);
      capIm.push_back(outIm);
      capSob.push_back(outSob);
      capCyc.push_back(cyc);
    end
  end

  function automatic logic [W-1:0] mkRe(int b, int i);
    return W'((b * 97 + i * 13 + 5) % 4096);
  endfunction

  function automatic logic [W-1:0] mkIm(int b, int i);
    return W'((b * 31 + i * 7 + 2000) % 4096);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idleCycle(int salt);
    @(negedge clk);
    inValid = 1'b0;
    inRe = W'(salt * 3 + 1);
    inIm = W'(~salt);
  endtask

  // one input block; gaps only before sample N-P, then gapAfter idle cycles
  task automatic driveBlock(int b, bit gappy, int gapAfter);
    for (int i = 0; i < N; i++) begin
      if (gappy && i < N - P && (i % 3) == 1) idleCycle(i);
      @(negedge clk);
      inValid = 1'b1;
      inRe = mkRe(b, i);
      inIm = mkIm(b, i);
      if (i == N - P) expStart.push_back(cyc + 2);
    end
    for (int j = 0; j < P; j++) begin
      expRe.push_back(mkRe(b, N - P + j));
      expIm.push_back(mkIm(b, N - P + j));
      expSob.push_back(j == 0);
    end
    for (int i = 0; i < N; i++) begin
      expRe.push_back(mkRe(b, i));
      expIm.push_back(mkIm(b, i));
      expSob.push_back(1'b0);
    end
    for (int g = 0; g < gapAfter; g++) idleCycle(g + 100);
  endtask

  task automatic verifyRun(bit chain, string extra);
    for (int g = 0; g < N + P + 6; g++) idleCycle(g + 500);
    check("R2", "captured sample count", capRe.size(), expRe.size());
    if (capRe.size() == expRe.size()) begin
      for (int b = 0; b < expStart.size(); b++) begin
        int base = b * (N + P);
        check("R6", "first output cycle", capCyc[base], expStart[b]);
        if (chain && b > 0)
          check("R8 R9", "block follows previous with no gap", capCyc[base], capCyc[base - 1] + 1);
        for (int j = 0; j < N + P; j++) begin
          int k = base + j;
          string tag = (j < P) ? {"R3", extra} : {"R4", extra};
          check("R2", "consecutive output cycle", capCyc[k], capCyc[base] + j);
          check(tag, "real part", int'(capRe[k]), int'(expRe[k]));
          check(tag, "imaginary part", int'(capIm[k]), int'(expIm[k]));
          check("R5", "start-of-block flag", int'(capSob[k]), int'(expSob[k]));
        end
      end
    end
    capRe.delete(); capIm.delete(); capSob.delete(); capCyc.delete();
    expRe.delete(); expIm.delete(); expSob.delete(); expStart.delete();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    inValid = 1'b0;
    inRe = '0;
    inIm = '0;
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "outSob in reset", int'(outSob), 0);
    rstN = 1'b1;
    for (int g = 0; g < 5; g++) idleCycle(g);
    check("R1", "outValid idle after reset", int'(outValid), 0);
    check("R1", "outSob idle after reset", int'(outSob), 0);
    check("R1", "no output captured while idle", capRe.size(), 0);
  endtask

  task automatic testBackToBack();
    driveBlock(0, 1'b0, P);
    driveBlock(1, 1'b0, P);
    driveBlock(2, 1'b0, P);
    verifyRun(1'b1, "");
  endtask

  task automatic testGapped();
    driveBlock(10, 1'b1, P + 3);
    driveBlock(11, 1'b1, 2 * P);
    verifyRun(1'b0, " R7");
  endtask

  task automatic testLongIdle();
    driveBlock(20, 1'b0, 3 * N);
    driveBlock(21, 1'b0, P);
    verifyRun(1'b0, "");
  endtask

  initial begin
    testReset();
    testBackToBack();
    testGapped();
    testLongIdle();
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule